// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block takes interrupts for a small CPU control unit. Request pulses on a vector of lines are latched into a pending set. The set is examined only when the control unit signals that an instruction has finished. At that point, a request is taken if interrupts are enabled in the incoming status word and no handler is already running.

Taking a request runs a short fixed sequence:

- The lowest-numbered pending line wins, and its pending bit is dropped.
- The program counter and status word in force are copied into dedicated save registers.
- A new status word is issued with supervisor mode on and interrupts off.
- The handler address is read from a vector table whose base is held in a programmable register.
- The handler address is handed back as the new program counter.

A return strobe reloads the saved counter and status word, which also brings back the earlier mode and enable state.

The control unit holds its program counter and status word steady while the busy output is high. It applies new values only on the load strobes.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, busy, vec_rd, pc_load and psw_load are 0, and vec_addr, ipc, ipsw, new_pc and new_psw are all 0. The vector base register and the pending set are also cleared.
- R2: A request is taken only at a rising edge where all of the following hold:
  - instr_bnd is 1 and rti is 0;
  - psw_in bit 6 (interrupt enable) is 1;
  - the block is idle and no handler is running;
  - at least one line is pending.
  A line is pending only if its irq_in pulse came at an earlier edge, so a pulse in the boundary cycle itself is not seen at that boundary.
- R3: At the accepting edge, ipc takes pc_in and ipsw takes psw_in. Both then hold until the next accepting edge, whatever pc_in and psw_in do.
- R4: Call the accepting cycle t. busy is 1 in cycles t+1 and t+2 only.
- R5: In cycle t+2, psw_load is 1 and new_psw equals ipsw with bit 7 (supervisor) set and bit 6 (interrupt enable) cleared. All other bits are kept.
- R6: In cycle t+2, vec_rd is 1 and vec_addr equals the vector base plus 4 times the winning line index, modulo 2^AW. vec_rdata is sampled in that cycle. In cycle t+3, pc_load is 1 and new_pc equals that sampled word. Outside the vector-read cycle, vec_rd is 0 and vec_addr is 0.
- R7: When several lines are pending, the lowest-numbered one wins. The others stay pending and are taken at later boundaries in ascending order.
- R8: The winning line's pending bit is cleared at the accepting edge. With no new pulse on that line, it is not taken again.
- R9: From the accepting edge until an rti, no request is taken, even if instr_bnd and psw_in bit 6 are both 1.
- R10: An rti while not busy makes pc_load and psw_load 1 in the next cycle, with new_pc = ipc and new_psw = ipsw. It also ends the handler hold. When rti and instr_bnd are 1 in the same cycle, the return is done and no request is taken.
- R11: When ivec_we is 1 at an edge, the vector base becomes ivec_wdata. Entries that start after that edge use the new base.
- R12: The entry psw_load and pc_load strobes each last exactly one cycle.
- R13: instr_bnd and rti have no effect while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Request pulses, one per line |
| instr_bnd | input | 1 | Instruction-boundary strobe |
| rti | input | 1 | Return-from-interrupt strobe |
| pc_in | input | AW | Current program counter |
| psw_in | input | PSW_W | Current status word |
| ivec_we | input | 1 | Vector base write enable |
| ivec_wdata | input | AW | Vector base write value |
| vec_rdata | input | AW | Vector table word, valid in the read cycle |
| busy | output | 1 | Entry sequence in progress |
| vec_rd | output | 1 | Vector table read request |
| vec_addr | output | AW | Vector table entry address |
| pc_load | output | 1 | Apply new_pc |
| new_pc | output | AW | Program counter to apply |
| psw_load | output | 1 | Apply new_psw |
| new_psw | output | PSW_W | Status word to apply |
| ipc | output | AW | Saved program counter |
| ipsw | output | PSW_W | Saved status word |

## Verification
The hardest situation to reach from the ports is a boundary in which several lines are pending while a handler is still open. Only there do the hold and the leftover-pending behaviour both show.

The stimulus pulses every non-empty subset of the lines at once, for three vector bases (one of which makes the entry address wrap). It then walks the subset through repeated entry and return pairs. In each pair it tries an extra boundary before the return, and it drives boundary and return strobes in the middle of the sequence. The expected winner, address, handler word and status are computed from the subset in the bench.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SAVE = 2'd1,
      ST_VEC  = 2'd2
   } seq_state_t;

   localparam int VEC_SHIFT = 2;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
   parameter int NUM_IRQ = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] set_i,
   input  logic [NUM_IRQ-1:0] clr_i,
   output logic [NUM_IRQ-1:0] pend_o
);
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n)
            pend_o[i] <= 1'b0;
         else if (set_i[i])
            pend_o[i] <= 1'b1;
         else if (clr_i[i])
            pend_o[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NUM_IRQ = 4,
   parameter int IW      = 2
) (
   input  logic [NUM_IRQ-1:0] req_i,
   output logic               any_o,
   output logic [IW-1:0]      idx_o,
   output logic [NUM_IRQ-1:0] grant_o
);
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_grant
      if (i == 0) begin : g_first
         assign grant_o[i] = req_i[0];
      end else begin : g_rest
         assign grant_o[i] = req_i[i] & ~(|req_i[i-1:0]);
      end
   end

   assign any_o = |req_i;

   always_comb begin
      idx_o = '0;
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
         if (req_i[i])
            idx_o = IW'(i);
      end
   end
endmodule

// File: rtl/irq_save_regs.sv
module irq_save_regs #(
   parameter int AW    = 16,
   parameter int PSW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_i,
   input  logic [AW-1:0]    pc_i,
   input  logic [PSW_W-1:0] psw_i,
   input  logic             base_we_i,
   input  logic [AW-1:0]    base_d_i,
   output logic [AW-1:0]    ipc_o,
   output logic [PSW_W-1:0] ipsw_o,
   output logic [AW-1:0]    base_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ipc_o  <= '0;
         ipsw_o <= '0;
      end else if (cap_i) begin
         ipc_o  <= pc_i;
         ipsw_o <= psw_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         base_o <= '0;
      else if (base_we_i)
         base_o <= base_d_i;
   end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_seq_pkg::*;
#(
   parameter int NUM_IRQ = 4,
   parameter int AW      = 16,
   parameter int PSW_W   = 8,
   parameter int SUP_BIT = 7,
   parameter int IE_BIT  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_in,
   input  logic               instr_bnd,
   input  logic               rti,
   input  logic [AW-1:0]      pc_in,
   input  logic [PSW_W-1:0]   psw_in,
   input  logic               ivec_we,
   input  logic [AW-1:0]      ivec_wdata,
   input  logic [AW-1:0]      vec_rdata,
   output logic               busy,
   output logic               vec_rd,
   output logic [AW-1:0]      vec_addr,
   output logic               pc_load,
   output logic [AW-1:0]      new_pc,
   output logic               psw_load,
   output logic [PSW_W-1:0]   new_psw,
   output logic [AW-1:0]      ipc,
   output logic [PSW_W-1:0]   ipsw
);
   localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
   localparam logic [PSW_W-1:0] SUP_MASK = PSW_W'(1) << SUP_BIT;
   localparam logic [PSW_W-1:0] IE_MASK  = PSW_W'(1) << IE_BIT;

   if (NUM_IRQ < 1) begin : g_bad_n
      $error("NUM_IRQ must be at least 1");
   end
   if (SUP_BIT >= PSW_W || IE_BIT >= PSW_W || SUP_BIT == IE_BIT) begin : g_bad_bits
      $error("SUP_BIT and IE_BIT must be distinct bits of the status word");
   end
   if (AW <= IW + VEC_SHIFT) begin : g_bad_aw
      $error("AW too narrow for the vector table offset");
   end

   seq_state_t         st;
   logic               hold;
   logic [IW-1:0]      win_idx;
   logic [NUM_IRQ-1:0] pend;
   logic [NUM_IRQ-1:0] grant;
   logic [NUM_IRQ-1:0] clr_mask;
   logic               any_pend;
   logic [IW-1:0]      enc_idx;
   logic [AW-1:0]      ivec;
   logic               accept;
   logic [AW-1:0]      idx_ext;

   assign accept   = (st == ST_IDLE) && instr_bnd && !rti && psw_in[IE_BIT]
                     && !hold && any_pend;
   assign clr_mask = accept ? grant : '0;

   irq_pend_reg #(.NUM_IRQ(NUM_IRQ)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (irq_in),
      .clr_i  (clr_mask),
      .pend_o (pend)
   );

   irq_prio_enc #(.NUM_IRQ(NUM_IRQ), .IW(IW)) u_prio (
      .req_i   (pend),
      .any_o   (any_pend),
      .idx_o   (enc_idx),
      .grant_o (grant)
   );

   irq_save_regs #(.AW(AW), .PSW_W(PSW_W)) u_save (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_i     (accept),
      .pc_i      (pc_in),
      .psw_i     (psw_in),
      .base_we_i (ivec_we),
      .base_d_i  (ivec_wdata),
      .ipc_o     (ipc),
      .ipsw_o    (ipsw),
      .base_o    (ivec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         hold     <= 1'b0;
         win_idx  <= '0;
         pc_load  <= 1'b0;
         psw_load <= 1'b0;
         new_pc   <= '0;
         new_psw  <= '0;
      end else begin
         pc_load  <= 1'b0;
         psw_load <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (rti) begin
                  new_pc   <= ipc;
                  new_psw  <= ipsw;
                  pc_load  <= 1'b1;
                  psw_load <= 1'b1;
                  hold     <= 1'b0;
               end else if (accept) begin
                  st      <= ST_SAVE;
                  hold    <= 1'b1;
                  win_idx <= enc_idx;
               end
            end
            ST_SAVE: begin
               new_psw  <= (ipsw | SUP_MASK) & ~IE_MASK;
               psw_load <= 1'b1;
               st       <= ST_VEC;
            end
            ST_VEC: begin
               new_pc  <= vec_rdata;
               pc_load <= 1'b1;
               st      <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign idx_ext  = {{(AW - IW){1'b0}}, win_idx};
   assign busy     = (st != ST_IDLE);
   assign vec_rd   = (st == ST_VEC);
   assign vec_addr = vec_rd ? (ivec + (idx_ext << VEC_SHIFT)) : '0;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
   parameter int AW      = 16,
   parameter int PSW_W   = 8,
   parameter int SUP_BIT = 7,
   parameter int IE_BIT  = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rti,
   input logic             busy,
   input logic             vec_rd,
   input logic [AW-1:0]    vec_rdata,
   input logic             pc_load,
   input logic [AW-1:0]    new_pc,
   input logic             psw_load,
   input logic [PSW_W-1:0] new_psw,
   input logic [AW-1:0]    ipc,
   input logic [PSW_W-1:0] ipsw
);
   p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy);

   p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |=> !busy);

   p_vec_in_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_rd |-> (busy && $past(busy)));

   p_handler_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_rd |=> (pc_load && new_pc == $past(vec_rdata)));

   p_entry_psw_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (psw_load && busy) |-> (new_psw[SUP_BIT] && !new_psw[IE_BIT]));

   p_psw_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (psw_load && busy) |=> !psw_load);

   p_save_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(busy) |-> ($stable(ipc) && $stable(ipsw)));

   p_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rti && !busy) |=> (pc_load && psw_load && new_pc == $past(ipc)
                          && new_psw == $past(ipsw)));
endmodule

bind irq_entry_seq irq_entry_chk #(
   .AW(AW), .PSW_W(PSW_W), .SUP_BIT(SUP_BIT), .IE_BIT(IE_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rti       (rti),
   .busy      (busy),
   .vec_rd    (vec_rd),
   .vec_rdata (vec_rdata),
   .pc_load   (pc_load),
   .new_pc    (new_pc),
   .psw_load  (psw_load),
   .new_psw   (new_psw),
   .ipc       (ipc),
   .ipsw      (ipsw)
);

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;
   localparam int N  = 4;
   localparam int AW = 16;
   localparam int PW = 8;
   localparam logic [AW-1:0] VXOR = 16'hA5A0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = '0;
   logic          instr_bnd = 1'b0;
   logic          rti = 1'b0;
   logic [AW-1:0] pc_in = '0;
   logic [PW-1:0] psw_in = '0;
   logic          ivec_we = 1'b0;
   logic [AW-1:0] ivec_wdata = '0;
   logic [AW-1:0] vec_rdata;
   logic          busy, vec_rd, pc_load, psw_load;
   logic [AW-1:0] vec_addr, new_pc, ipc;
   logic [PW-1:0] new_psw, ipsw;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   assign vec_rdata = vec_addr ^ VXOR;

   irq_entry_seq dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .instr_bnd(instr_bnd),
      .rti(rti), .pc_in(pc_in), .psw_in(psw_in), .ivec_we(ivec_we),
      .ivec_wdata(ivec_wdata), .vec_rdata(vec_rdata), .busy(busy),
      .vec_rd(vec_rd), .vec_addr(vec_addr), .pc_load(pc_load),
      .new_pc(new_pc), .psw_load(psw_load), .new_psw(new_psw),
      .ipc(ipc), .ipsw(ipsw)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic set_base(logic [AW-1:0] b);
      @(posedge clk); #1 ivec_we = 1'b1; ivec_wdata = b;
      @(posedge clk); #1 ivec_we = 1'b0;
   endtask

   task automatic pulse_irq(logic [N-1:0] m);
      @(posedge clk); #1 irq_in = m;
      @(posedge clk); #1 irq_in = '0;
   endtask

   // One entry followed by a return; expects line idx to win.
   task automatic entry_return(logic [AW-1:0] base, int idx,
                               logic [AW-1:0] pc, logic [PW-1:0] psw);
      logic [AW-1:0] ea;
      logic [PW-1:0] ep;
      ea = base + AW'(idx * 4);
      ep = (psw | 8'h80) & 8'hBF;
      @(posedge clk); #1 instr_bnd = 1'b1; pc_in = pc; psw_in = psw;
      @(negedge clk); chk("R2 idle before accept", 32'(busy), 0);
      @(posedge clk); #1 instr_bnd = 1'b1; rti = 1'b1; pc_in = ~pc; psw_in = ~psw;
      @(negedge clk);
      chk("R4 busy t+1", 32'(busy), 1);
      chk("R3 ipc", 32'(ipc), 32'(pc));
      chk("R3 ipsw", 32'(ipsw), 32'(psw));
      chk("R6 no read t+1", 32'(vec_rd), 0);
      @(posedge clk); #1 instr_bnd = 1'b0; rti = 1'b0;
      @(negedge clk);
      chk("R4 busy t+2", 32'(busy), 1);
      chk("R6 vec_rd", 32'(vec_rd), 1);
      chk("R6 R7 R11 vec_addr", 32'(vec_addr), 32'(ea));
      chk("R5 psw_load", 32'(psw_load), 1);
      chk("R5 new_psw", 32'(new_psw), 32'(ep));
      chk("R13 rti ignored while busy", 32'(pc_load), 0);
      chk("R3 ipc held", 32'(ipc), 32'(pc));
      @(posedge clk); #1 instr_bnd = 1'b1; psw_in = 8'h40;
      @(negedge clk);
      chk("R4 busy done", 32'(busy), 0);
      chk("R6 pc_load", 32'(pc_load), 1);
      chk("R6 new_pc", 32'(new_pc), 32'(ea ^ VXOR));
      chk("R12 psw_load one cycle", 32'(psw_load), 0);
      chk("R6 vec_addr idle", 32'(vec_addr), 0);
      @(posedge clk); #1 instr_bnd = 1'b0; rti = 1'b1;
      @(negedge clk);
      chk("R9 held during handler", 32'(busy), 0);
      chk("R12 pc_load one cycle", 32'(pc_load), 0);
      @(posedge clk); #1 rti = 1'b0;
      @(negedge clk);
      chk("R10 pc_load", 32'(pc_load), 1);
      chk("R10 psw_load", 32'(psw_load), 1);
      chk("R10 new_pc", 32'(new_pc), 32'(pc));
      chk("R10 new_psw", 32'(new_psw), 32'(psw));
   endtask

   task automatic try_boundary(string tag, logic [PW-1:0] psw, bit with_rti);
      @(posedge clk); #1 instr_bnd = 1'b1; psw_in = psw; rti = with_rti;
      @(posedge clk); #1 instr_bnd = 1'b0; rti = 1'b0;
      @(negedge clk); chk(tag, 32'(busy), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [AW-1:0] bases [3];
      bases[0] = 16'h0000; bases[1] = 16'h1230; bases[2] = 16'hFFF8;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 busy", 32'(busy), 0);
      chk("R1 vec_rd", 32'(vec_rd), 0);
      chk("R1 pc_load", 32'(pc_load), 0);
      chk("R1 psw_load", 32'(psw_load), 0);
      chk("R1 vec_addr", 32'(vec_addr), 0);
      chk("R1 ipc", 32'(ipc), 0);
      chk("R1 ipsw", 32'(ipsw), 0);
      chk("R1 new_pc", 32'(new_pc), 0);
      chk("R1 new_psw", 32'(new_psw), 0);
      @(posedge clk); #1 rst_n = 1'b1;

      // R1: base is 0 after reset; R2: no pending -> no entry.
      try_boundary("R2 nothing pending", 8'h40, 1'b0);
      // R2: pulse in the boundary cycle itself is not seen.
      @(posedge clk); #1 irq_in = 4'b0100; instr_bnd = 1'b1; psw_in = 8'h40;
      @(posedge clk); #1 irq_in = '0; instr_bnd = 1'b0;
      @(negedge clk); chk("R2 same-cycle pulse not taken", 32'(busy), 0);
      // R2: interrupts disabled in psw_in.
      try_boundary("R2 enable bit clear", 8'h00, 1'b0);
      // R10: rti wins over a boundary in the same cycle.
      try_boundary("R10 rti beats boundary", 8'h40, 1'b1);
      // R1: reset base used for line 2.
      entry_return(16'h0000, 2, 16'h0ABC, 8'h45);

      for (int b = 0; b < 3; b++) begin
         set_base(bases[b]);
         for (int m = 1; m < (1 << N); m++) begin
            logic [N-1:0] left;
            left = N'(m);
            pulse_irq(left);
            while (left != '0) begin
               int w;
               w = 0;
               for (int i = N - 1; i >= 0; i--) if (left[i]) w = i;
               entry_return(bases[b], w, AW'(16'h2000 + m * 16 + b * 4 + w),
                            8'h40 | PW'((m + w) & 8'h3F));
               left[w] = 1'b0;
            end
            try_boundary("R8 taken lines cleared", 8'h40, 1'b0);
         end
      end
      finish_run();
   end
endmodule